// File: doc/BRIEF.md
# Configurable GPIO Pin Bank

This block is one bank of up to 32 general-purpose pins sitting behind a plain 32-bit register bus. The bus has a byte address, a write strobe, write data and registered read data. Software uses per-pin configuration registers to make each pin one of three things: a general input, a general output that drives its pad, or an interrupt input. The block turns that configuration into a pad output value and a pad output-enable. It also brings the pad levels through a two-flop synchronizer into a readable input register.

Edge and level sensing is done by a separate interrupt block. This bank only hands that block four per-pin configuration vectors: interrupt mode, inverted polarity, edge trigger and dual edge. Every configuration register reads back exactly what was written, within the implemented pins, so a power manager can save the bank state and restore it. The output source register lets each output pin take its value from an alternate source (`alt_dout`) instead of the output data register.

Top module: `pinbank_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every configuration register clears to zero. After reset, every pin is therefore a non-inverted general input, `pad_oe` is all zero and the four exported vectors are zero.
- R2: Eight configuration registers are writable and read back what was written. Their byte offsets are: 0x00 interrupt mode (1 = interrupt input), 0x04 drive (1 = output), 0x08 output data, 0x20 invert (1 = active low), 0x24 trigger (1 = edge, 0 = level), 0x40 output source (1 = alt_dout), 0x4C dual edge (1 = both edges), 0x50 input enable.
- R3: Bits at and above position NPINS are never stored and always read as zero.
- R4: Pin i drives its pad (`pad_oe[i]` = 1) only when its interrupt mode bit is 0 and its drive bit is 1. Writing a 1 to a pin's interrupt mode bit releases that pad in the cycle after the write.
- R5: `pad_out[i]` takes the output data bit when pin i's output source bit is 0, and takes `alt_dout[i]` when that bit is 1.
- R6: Reading offset 0x0C returns the synchronized pad level for pins whose input enable bit is 1, and 0 for pins whose bit is 0. A pad change applied before clock edge k appears on `bus_rdata` after edge k+2, provided the address is held at 0x0C.
- R7: For a pin configured as an output, offset 0x0C still returns the level on `pad_in`, not the output data.
- R8: Reads of an offset that is not listed in R2 and is not 0x0C return zero. Writes to such offsets, and writes to 0x0C, change no register.
- R9: `irq_mode`, `irq_invert`, `irq_edge` and `irq_dual` equal the interrupt mode, invert, trigger and dual-edge registers.
- R10: `bus_rdata` is registered. It shows the register selected by the `bus_addr` value present at the previous clock edge, and a write becomes visible on the read of the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NPINS | Raw pad levels |
| alt_dout | input | NPINS | Alternate output data source |
| pad_out | output | NPINS | Value driven onto the pads |
| pad_oe | output | NPINS | Pad output enable |
| irq_mode | output | NPINS | Interrupt-input mode per pin |
| irq_invert | output | NPINS | Active-low polarity per pin |
| irq_edge | output | NPINS | Edge (1) or level (0) per pin |
| irq_dual | output | NPINS | Both-edge select per pin |

## Verification
A corrupted configuration register is not hidden anywhere. It shows up on the read of that offset in the next cycle, and at once on `pad_oe`, `pad_out` or the exported vectors if the affected field feeds them. A synchronizer that is too short or too long moves the input register update one edge earlier or later than the third edge. The bench therefore checks the old value after two edges and the new value after three. Wrong address decode shows as a nonzero read at an unused offset, or as a neighbouring register that changed after a write elsewhere.

// File: rtl/pinbank_pkg.sv
// Package: register offsets and helpers shared by the GPIO pin bank.
// Assumes byte addressing with 32-bit registers on word boundaries.
package pinbank_pkg;

    localparam int BUS_W = 32;
    localparam int NREG  = 8;

    typedef logic [BUS_W-1:0] word_t;

    // Index of each stored configuration register
    localparam int IX_MODE  = 0;
    localparam int IX_DRIVE = 1;
    localparam int IX_DOUT  = 2;
    localparam int IX_INV   = 3;
    localparam int IX_TRIG  = 4;
    localparam int IX_SRC   = 5;
    localparam int IX_DUAL  = 6;
    localparam int IX_INEN  = 7;

    localparam logic [7:0] OFS_INDATA = 8'h0C;

    // Byte offset of configuration register idx
    function automatic logic [7:0] reg_offset(input int idx);
        case (idx)
            IX_MODE:  return 8'h00;
            IX_DRIVE: return 8'h04;
            IX_DOUT:  return 8'h08;
            IX_INV:   return 8'h20;
            IX_TRIG:  return 8'h24;
            IX_SRC:   return 8'h40;
            IX_DUAL:  return 8'h4C;
            default:  return 8'h50;
        endcase
    endfunction

endpackage

// File: rtl/pinbank_regs.sv
// Module: configuration register file of the pin bank.
// Holds the eight read/write registers; writes are masked to NPINS bits.
// Assumes addresses wider than 8 bits are zero in their upper part for a hit.
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  word_t             wdata,
    output word_t             cfg [NREG]
);

    localparam logic [BUS_W:0] ONE_SH   = (BUS_W+1)'(1) << NPINS;
    localparam word_t          PIN_MASK = BUS_W'(ONE_SH - (BUS_W+1)'(1));

    logic [NREG-1:0] hit;
    word_t           cfg_q [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        // Decode: this register is addressed
        assign hit[k] = (addr == ADDR_W'(reg_offset(k)));

        // Storage: clear on reset, load masked data on an addressed write
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[k] <= '0;
            else if (we && hit[k])
                cfg_q[k] <= wdata & PIN_MASK;
        end

        assign cfg[k] = cfg_q[k];

        a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (we && hit[k]) |=> (cfg_q[k] == $past(wdata & PIN_MASK)));

        a_r8_miss_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (we && !hit[k]) |=> $stable(cfg_q[k]));

        a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (cfg_q[k] == '0));

        a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[k] & ~PIN_MASK) == '0);
    end

endmodule

// File: rtl/pinbank_sync.sv
// Module: two-flop synchronizer for the raw pad levels.
// Assumes pad_in may change at any time relative to clk.
module pinbank_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_sync
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [1:0]       warm_q;

    // Capture and re-time the pad levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_in;
            sync_q <= meta_q;
        end
    end

    // Count edges since reset for the latency check (saturates at 2)
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_q <= '0;
        else if (warm_q != 2'd2)
            warm_q <= warm_q + 2'd1;
    end

    assign d_sync = sync_q;

    a_r6_two_edge_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (sync_q == $past(d_in, 2)));

endmodule

// File: rtl/pinbank_pads.sv
// Module: pad-side logic: drive enable, output source select, input gating.
// Assumes configuration vectors are already masked to NPINS.
module pinbank_pads #(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] mode,
    input  logic [NPINS-1:0] drive,
    input  logic [NPINS-1:0] dout,
    input  logic [NPINS-1:0] src_alt,
    input  logic [NPINS-1:0] in_en,
    input  logic [NPINS-1:0] alt_dout,
    input  logic [NPINS-1:0] pad_sync,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] in_data
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        // Per-pin pad control and input gate
        always_comb begin
            pad_oe[i]  = !mode[i] && drive[i];
            pad_out[i] = src_alt[i] ? alt_dout[i] : dout[i];
            in_data[i] = pad_sync[i] && in_en[i];
        end
    end

endmodule

// File: rtl/pinbank_rdmux.sv
// Module: registered read data selector.
// Assumes cfg words are already masked; undefined offsets return zero.
module pinbank_rdmux
    import pinbank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             cfg [NREG],
    input  logic [NPINS-1:0]  in_data,
    output word_t             rdata
);

    localparam logic [BUS_W:0] ONE_SH   = (BUS_W+1)'(1) << NPINS;
    localparam word_t          PIN_MASK = BUS_W'(ONE_SH - (BUS_W+1)'(1));

    word_t rd_sel;
    logic  any_hit;

    // Select the addressed word
    always_comb begin
        rd_sel  = '0;
        any_hit = 1'b0;
        for (int k = 0; k < NREG; k++) begin
            if (addr == ADDR_W'(reg_offset(k))) begin
                rd_sel  = cfg[k];
                any_hit = 1'b1;
            end
        end
        if (addr == ADDR_W'(OFS_INDATA)) begin
            rd_sel  = BUS_W'(in_data);
            any_hit = 1'b1;
        end
    end

    // Register the read data
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd_sel;
    end

    a_r3_rdata_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~PIN_MASK) == '0);

    a_r8_undef_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |=> (rdata == '0));

endmodule

// File: rtl/pinbank_ctrl.sv
// Module: top of the GPIO pin bank.
// Connects register file, synchronizer, pad logic and read mux; exports
// the interrupt configuration vectors to the external sense block.
// Assumes a single bus master and synchronous active-low reset.
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    input  logic [NPINS-1:0]  alt_dout,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  irq_mode,
    output logic [NPINS-1:0]  irq_invert,
    output logic [NPINS-1:0]  irq_edge,
    output logic [NPINS-1:0]  irq_dual
);

    word_t            cfg [NREG];
    logic [NPINS-1:0] pad_sync;
    logic [NPINS-1:0] in_data;

    pinbank_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .we    (bus_we),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    pinbank_sync #(.WIDTH(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (pad_in),
        .d_sync (pad_sync)
    );

    pinbank_pads #(.NPINS(NPINS)) u_pads (
        .mode     (cfg[IX_MODE][NPINS-1:0]),
        .drive    (cfg[IX_DRIVE][NPINS-1:0]),
        .dout     (cfg[IX_DOUT][NPINS-1:0]),
        .src_alt  (cfg[IX_SRC][NPINS-1:0]),
        .in_en    (cfg[IX_INEN][NPINS-1:0]),
        .alt_dout (alt_dout),
        .pad_sync (pad_sync),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .in_data  (in_data)
    );

    pinbank_rdmux #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .cfg     (cfg),
        .in_data (in_data),
        .rdata   (bus_rdata)
    );

    // Exported configuration for the interrupt sense block
    assign irq_mode   = cfg[IX_MODE][NPINS-1:0];
    assign irq_invert = cfg[IX_INV][NPINS-1:0];
    assign irq_edge   = cfg[IX_TRIG][NPINS-1:0];
    assign irq_dual   = cfg[IX_DUAL][NPINS-1:0];

    a_r4_irq_mode_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(reg_offset(IX_MODE)))
        |=> ((pad_oe & $past(bus_wdata[NPINS-1:0])) == '0));

    a_r1_released_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && irq_mode == '0));

endmodule

// File: tb/pinbank_ctrl_test.sv
module pinbank_ctrl_test;

    localparam int NP = 24;
    localparam logic [31:0] MSK = 32'h00FF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] alt_dout = '0;
    logic [NP-1:0] pad_out, pad_oe, irq_mode, irq_invert, irq_edge, irq_dual;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pinbank_ctrl #(.NPINS(NP), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .alt_dout(alt_dout), .pad_out(pad_out), .pad_oe(pad_oe),
        .irq_mode(irq_mode), .irq_invert(irq_invert), .irq_edge(irq_edge),
        .irq_dual(irq_dual)
    );

    // {offset, write data, expected readback}
    localparam logic [71:0] VEC [8] = '{
        {8'h00, 32'hDEAD_BEEF, 32'h00AD_BEEF},
        {8'h04, 32'h1234_5678, 32'h0034_5678},
        {8'h08, 32'hFFFF_FFFF, 32'h00FF_FFFF},
        {8'h20, 32'h0F0F_0F0F, 32'h000F_0F0F},
        {8'h24, 32'hA5A5_A5A5, 32'h00A5_A5A5},
        {8'h40, 32'h0000_0001, 32'h0000_0001},
        {8'h4C, 32'h8000_0000, 32'h0000_0000},
        {8'h50, 32'h00C3_C3C3, 32'h00C3_C3C3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, m, d, o, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int k = 0; k < 8; k++) begin
            rd(VEC[k][71:64], v);
            check("R1 reg after reset", v, 32'h0);
        end
        check("R1 pad_oe after reset", 32'(pad_oe), 32'h0);
        check("R1 exports after reset", 32'(irq_mode | irq_invert | irq_edge | irq_dual), 32'h0);

        // R2/R3/R10: table walk, write then read back next cycle
        for (int k = 0; k < 8; k++) begin
            wr(VEC[k][71:64], VEC[k][63:32]);
            rd(VEC[k][71:64], v);
            check("R2 R3 R10 readback", v, VEC[k][31:0]);
        end

        // R9: exports mirror the registers
        check("R9 irq_mode", 32'(irq_mode), 32'h00AD_BEEF);
        check("R9 irq_invert", 32'(irq_invert), 32'h000F_0F0F);
        check("R9 irq_edge", 32'(irq_edge), 32'h00A5_A5A5);
        check("R9 irq_dual", 32'(irq_dual), 32'h0);

        // R4: drive only in general mode with drive bit set
        check("R4 pad_oe mixed", 32'(pad_oe), ~32'h00AD_BEEF & 32'h0034_5678 & MSK);
        wr(8'h04, 32'h00FF_FFFF);
        wr(8'h00, 32'h0000_0F0F);
        check("R4 irq-mode pins released", 32'(pad_oe), 32'h00FF_F0F0);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0);
        check("R4 inputs do not drive", 32'(pad_oe), 32'h0);

        // R5: output source select
        d = 32'h00A5_A5A5; o = 32'h005A_5A5A; s = 32'h0000_FF00;
        alt_dout = o[NP-1:0];
        wr(8'h08, d);
        wr(8'h40, s);
        check("R5 pad_out mixed source", 32'(pad_out), (d & ~s) | (o & s));
        wr(8'h40, MSK);
        check("R5 pad_out all alternate", 32'(pad_out), o);
        wr(8'h40, 32'h0);
        check("R5 pad_out all register", 32'(pad_out), d);

        // R6: input gate and synchronizer latency
        wr(8'h50, 32'h0);
        @(negedge clk); pad_in = 24'h123456; bus_addr = 8'h0C;
        repeat (4) @(negedge clk);
        check("R6 disabled inputs read zero", bus_rdata, 32'h0);
        wr(8'h50, 32'h0000_FFFF);
        rd(8'h0C, v);
        check("R6 partial enable", v, 32'h0000_3456);
        @(negedge clk); pad_in = 24'h00ABCD;
        repeat (2) @(negedge clk);
        check("R6 not visible after two edges", bus_rdata, 32'h0000_3456);
        @(negedge clk);
        check("R6 visible after third edge", bus_rdata, 32'h0000_ABCD);

        // R7: output pins still report the pad level
        wr(8'h50, MSK);
        wr(8'h08, 32'h0);
        wr(8'h04, MSK);
        @(negedge clk); pad_in = 24'hFFFFFF; bus_addr = 8'h0C;
        repeat (4) @(negedge clk);
        check("R7 output pin reads pad", bus_rdata, 32'h00FF_FFFF);

        // R8: undefined offsets and the read-only input register
        wr(8'h0C, 32'h0);
        rd(8'h0C, v);
        check("R8 input reg write ignored", v, 32'h00FF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h44, v);
        check("R8 undefined reads zero", v, 32'h0);
        wr(8'h01, 32'h0000_00FF);
        rd(8'h00, v);
        check("R8 unaligned write ignored", v, 32'h0);
        rd(8'h04, m);
        check("R8 neighbour unchanged", m, MSK);

        // R1: reset in mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 pad_oe after second reset", 32'(pad_oe), 32'h0);
        rd(8'h04, v);
        check("R1 drive reg after second reset", v, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule